// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits beside the bit engine of an I2C master that shares the bus with other masters. The engine still sequences bits, issues START and STOP, and counts bit and byte positions. This block watches the resolved SCL and SDA levels and decides whether this master still owns the transfer. Whenever the engine presents a sample strobe during a synchronized SCL high phase, the block compares the level this master wants on SDA with the level actually on the wire. A master that leaves SDA released (drives a 1) but sees a 0 has lost. From then on the block keeps SDA released, holds a sticky loss flag, and raises a window telling the engine to keep clocking until the acknowledge slot of the current byte has been sampled.

The block also tracks START and STOP conditions on the wire. From these it derives a bus-busy state and permits a retry only once a STOP has followed the loss. It flags a START or STOP that appears in the middle of one of this master's bytes, and that the engine did not generate, as a loss. While the first byte of a frame goes by, it collects the address bits. If this master has lost by the time the read/write bit is sampled and the collected address equals its own address, it raises a handoff so slave logic can take over at once.

Top module: `i2c_arb_monitor`

## Requirements
- R1: A compare happens only on a cycle where `sample_stb` and `scl_in` are both 1. A compare with `drv_en`=1, `drv_bit`=1 and `sda_in`=0 while this master owns the frame sets `arb_lost` on the next cycle. The same mismatch with `scl_in`=0 has no effect.
- R2: `sda_oe` (1 = pull SDA low) equals `drv_en` AND NOT `drv_bit` while `arb_lost` is 0, and is 0 whenever `arb_lost` is 1.
- R3: `tail_clk` goes to 1 on the cycle after a loss and returns to 0 on the cycle after a strobed sample with `bit_idx`=8 (the acknowledge slot), or after any START or STOP. A loss at the acknowledge slot, or one caused by a START or STOP, does not raise it.
- R4: A START (SDA 1 to 0 while SCL stays 1) marks the bus busy, and a STOP (SDA 0 to 1 while SCL stays 1) marks it free. `retry_ok` is 1 only when the bus is free and no loss is waiting for a STOP. A STOP clears the waiting loss, even a loss raised in the same cycle.
- R5: A sample at the acknowledge slot (`bit_idx`=8) is compared like any address or data bit.
- R6: `arb_lost` stays 1 until `clr_lost` or `own_start` is asserted. A new loss in the same cycle takes precedence over the clear.
- R7: In byte 0 (`byte_cnt`=0), the levels sampled at `bit_idx` 0 to 6 form the address, first sample as its MSB. On the strobed sample at `bit_idx`=7, if a loss has occurred (earlier or in that cycle) and the address equals `own_addr`, `slave_hit` is 1 from the next cycle. A START or STOP on the bus, or `own_start`, clears it.
- R8: While this master owns the frame and `gen_cond`=0, a START or STOP seen at a nonzero `bit_idx` is a loss. With `gen_cond`=1, or at `bit_idx`=0, it is not.
- R9: After reset `arb_lost`, `tail_clk` and `slave_hit` are 0 and `retry_ok` is 1.
- R10: This master owns the frame from the cycle after `own_start` until `own_stop` or a loss. A mismatch outside that span does not set `arb_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Resolved SCL level, already synchronized |
| sda_in | input | 1 | Resolved SDA level, already synchronized |
| sample_stb | input | 1 | Sample point inside a synchronized SCL high phase |
| drv_en | input | 1 | Engine is the SDA transmitter for this bit |
| drv_bit | input | 1 | Level the engine wants on SDA |
| bit_idx | input | 4 | Bit slot in byte, 0 to 7 data (MSB first), 8 acknowledge |
| byte_cnt | input | BCNT_W | Byte number in the frame, 0 = address byte |
| own_addr | input | ADDR_W | Address this device answers to as a slave |
| own_start | input | 1 | Pulse: engine begins its own frame |
| own_stop | input | 1 | Pulse: engine ends its own frame |
| gen_cond | input | 1 | Engine is generating a START or STOP itself |
| clr_lost | input | 1 | Pulse: clear the loss flag |
| sda_oe | output | 1 | Pull SDA low |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| tail_clk | output | 1 | Keep clocking to the end of the current byte |
| retry_ok | output | 1 | A new attempt may start |
| slave_hit | output | 1 | Lost during the address byte and addressed as slave |

## Verification
The hardest state to reach is a handoff to slave mode. It needs a frame this master owns, seven address samples whose levels spell the own address, and a loss at one of those samples before the read/write slot is reached. Random levels hit that only about once in a hundred address bytes. A directed walk therefore sets SDA to the address bits one slot at a time while the engine insists on driving ones, then repeats the walk with a wrong address. The random phase runs throughout against a per-cycle model of every output. It mixes frequent SCL-high cycles with random SDA flips, so that foreign STARTs and STOPs land at nonzero bit slots with `gen_cond` low.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
    localparam int unsigned BIT_IDX_W = 4;
    localparam logic [BIT_IDX_W-1:0] ACK_SLOT = 4'd8;

    typedef struct packed {
        logic start;
        logic stop;
    } bus_evt_t;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
    import i2c_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    input  logic     lose_evt,
    output bus_evt_t evt,
    output logic     retry_ok
);
    typedef struct packed {
        logic scl;
        logic sda;
        logic busy;
        logic pend;
    } cond_st_t;

    cond_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        evt.start = scl_in & st_q.scl & st_q.sda & ~sda_in;
        evt.stop  = scl_in & st_q.scl & ~st_q.sda & sda_in;
        st_d.scl  = scl_in;
        st_d.sda  = sda_in;
        if (evt.start) begin
            st_d.busy = 1'b1;
        end else if (evt.stop) begin
            st_d.busy = 1'b0;
        end
        st_d.pend = evt.stop ? 1'b0 : (st_q.pend | lose_evt);
        retry_ok  = ~st_q.busy & ~st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl: 1'b1, sda: 1'b1, busy: 1'b0, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    p_free_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> retry_ok);
    p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> !retry_ok);
endmodule

// File: rtl/i2c_bit_arb.sv
module i2c_bit_arb
    import i2c_arb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 sample_stb,
    input  logic                 drv_en,
    input  logic                 drv_bit,
    input  logic [BIT_IDX_W-1:0] bit_idx,
    input  logic                 own_start,
    input  logic                 own_stop,
    input  logic                 gen_cond,
    input  logic                 clr_lost,
    input  bus_evt_t             evt,
    output logic                 lose_evt,
    output logic                 arb_lost,
    output logic                 tail_clk,
    output logic                 sda_oe
);
    typedef struct packed {
        logic own;
        logic lost;
        logic tail;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    smp_ok;
    logic    cmp_lose;
    logic    cond_lose;
    logic    byte_end;

    always_comb begin
        st_d      = st_q;
        smp_ok    = sample_stb & scl_in;
        cmp_lose  = st_q.own & smp_ok & drv_en & drv_bit & ~sda_in;
        cond_lose = st_q.own & (evt.start | evt.stop) & ~gen_cond & (bit_idx != '0);
        lose_evt  = cmp_lose | cond_lose;
        byte_end  = (smp_ok & (bit_idx == ACK_SLOT)) | evt.start | evt.stop;

        st_d.lost = lose_evt | (st_q.lost & ~(clr_lost | own_start));
        st_d.own  = own_start | (st_q.own & ~own_stop & ~lose_evt);
        st_d.tail = byte_end ? 1'b0 : (st_q.tail | lose_evt);

        arb_lost  = st_q.lost;
        tail_clk  = st_q.tail;
        sda_oe    = drv_en & ~drv_bit & ~st_q.lost;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_loss_in_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lost) |-> $past(scl_in));
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lost && !clr_lost && !own_start) |=> st_q.lost);
    p_tail_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tail && smp_ok && bit_idx == ACK_SLOT) |=> !st_q.tail);
    p_tail_after_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tail) |-> st_q.lost);
endmodule

// File: rtl/i2c_addr_snoop.sv
module i2c_addr_snoop
    import i2c_arb_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned BCNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 sample_stb,
    input  logic [BIT_IDX_W-1:0] bit_idx,
    input  logic [BCNT_W-1:0]    byte_cnt,
    input  logic [ADDR_W-1:0]    own_addr,
    input  logic                 lost_now,
    input  logic                 clr_evt,
    output logic                 slave_hit
);
    localparam logic [BIT_IDX_W-1:0] RW_SLOT = BIT_IDX_W'(ADDR_W);

    typedef struct packed {
        logic [ADDR_W-1:0] sh;
        logic              hit;
    } snoop_st_t;

    snoop_st_t st_d, st_q;
    logic      addr_smp;
    logic      match;

    always_comb begin
        st_d     = st_q;
        addr_smp = sample_stb & scl_in & (byte_cnt == '0);
        if (addr_smp && bit_idx < RW_SLOT) begin
            st_d.sh = {st_q.sh[ADDR_W-2:0], sda_in};
        end
        match    = addr_smp & (bit_idx == RW_SLOT) & lost_now & (st_q.sh == own_addr);
        st_d.hit = clr_evt ? 1'b0 : (st_q.hit | match);
        slave_hit = st_q.hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_hit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> !st_q.hit);
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
    import i2c_arb_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned BCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              sample_stb,
    input  logic              drv_en,
    input  logic              drv_bit,
    input  logic [3:0]        bit_idx,
    input  logic [BCNT_W-1:0] byte_cnt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              own_start,
    input  logic              own_stop,
    input  logic              gen_cond,
    input  logic              clr_lost,
    output logic              sda_oe,
    output logic              arb_lost,
    output logic              tail_clk,
    output logic              retry_ok,
    output logic              slave_hit
);
    bus_evt_t evt;
    logic     lose_evt;
    logic     lost_now;
    logic     clr_evt;

    assign lost_now = arb_lost | lose_evt;
    assign clr_evt  = evt.start | evt.stop | own_start;

    i2c_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .lose_evt (lose_evt),
        .evt      (evt),
        .retry_ok (retry_ok)
    );

    i2c_bit_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .sample_stb (sample_stb),
        .drv_en     (drv_en),
        .drv_bit    (drv_bit),
        .bit_idx    (bit_idx),
        .own_start  (own_start),
        .own_stop   (own_stop),
        .gen_cond   (gen_cond),
        .clr_lost   (clr_lost),
        .evt        (evt),
        .lose_evt   (lose_evt),
        .arb_lost   (arb_lost),
        .tail_clk   (tail_clk),
        .sda_oe     (sda_oe)
    );

    i2c_addr_snoop #(.ADDR_W(ADDR_W), .BCNT_W(BCNT_W)) u_snoop (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .sample_stb (sample_stb),
        .bit_idx    (bit_idx),
        .byte_cnt   (byte_cnt),
        .own_addr   (own_addr),
        .lost_now   (lost_now),
        .clr_evt    (clr_evt),
        .slave_hit  (slave_hit)
    );

    p_loss_blocks_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lose_evt && !evt.stop) |=> !retry_ok);
    p_oe_low_after_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lose_evt |=> !sda_oe);
endmodule

// File: tb/sim_i2c_arb_monitor.sv
module sim_i2c_arb_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_scl = 1'b1, b_sda = 1'b1, b_stb = 1'b0;
    logic       b_den = 1'b0, b_dbit = 1'b0;
    logic [3:0] b_bidx = 4'd0;
    logic [7:0] b_bcnt = 8'd0;
    logic [6:0] b_addr = 7'h5A;
    logic       b_ostart = 1'b0, b_ostop = 1'b0, b_gen = 1'b0, b_clr = 1'b0;
    logic       sda_oe, arb_lost, tail_clk, retry_ok, slave_hit;

    int total = 0;
    int bad = 0;

    logic       m_pscl, m_psda, m_busy, m_pend, m_own, m_lost, m_tail, m_hit;
    logic [6:0] m_sh;

    always #10 clk = ~clk;

    i2c_arb_monitor u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(b_scl), .sda_in(b_sda),
        .sample_stb(b_stb), .drv_en(b_den), .drv_bit(b_dbit),
        .bit_idx(b_bidx), .byte_cnt(b_bcnt), .own_addr(b_addr),
        .own_start(b_ostart), .own_stop(b_ostop), .gen_cond(b_gen),
        .clr_lost(b_clr), .sda_oe(sda_oe), .arb_lost(arb_lost),
        .tail_clk(tail_clk), .retry_ok(retry_ok), .slave_hit(slave_hit)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_pscl = 1'b1; m_psda = 1'b1; m_busy = 1'b0; m_pend = 1'b0;
        m_own = 1'b0; m_lost = 1'b0; m_tail = 1'b0; m_hit = 1'b0; m_sh = '0;
    endfunction

    function automatic void model_step();
        logic st, sp, smp, lose, endb, asmp, match;
        st    = b_scl && m_pscl && m_psda && !b_sda;
        sp    = b_scl && m_pscl && !m_psda && b_sda;
        smp   = b_stb && b_scl;
        lose  = (m_own && smp && b_den && b_dbit && !b_sda) ||
                (m_own && (st || sp) && !b_gen && b_bidx != 4'd0);
        endb  = (smp && b_bidx == 4'd8) || st || sp;
        asmp  = smp && b_bcnt == 8'd0;
        match = asmp && b_bidx == 4'd7 && (m_lost || lose) && m_sh == b_addr;
        if (asmp && b_bidx < 4'd7) m_sh = {m_sh[5:0], b_sda};
        m_hit  = (st || sp || b_ostart) ? 1'b0 : (m_hit || match);
        m_tail = endb ? 1'b0 : (m_tail || lose);
        m_lost = lose || (m_lost && !(b_clr || b_ostart));
        m_own  = b_ostart || (m_own && !b_ostop && !lose);
        m_pend = sp ? 1'b0 : (m_pend || lose);
        if (st) m_busy = 1'b1;
        else if (sp) m_busy = 1'b0;
        m_pscl = b_scl;
        m_psda = b_sda;
    endfunction

    // Compare all outputs with the model, advance one clock; returns at negedge.
    task automatic tick();
        #2;
        chk(sda_oe, b_den && !b_dbit && !m_lost, "R2 sda_oe");
        chk(arb_lost, m_lost, "R6 arb_lost");
        chk(tail_clk, m_tail, "R3 tail_clk");
        chk(retry_ok, !m_busy && !m_pend, "R4 retry_ok");
        chk(slave_hit, m_hit, "R7 slave_hit");
        if (!rst_n) model_reset();
        else model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setb(input logic scl, input logic sda, input logic stb,
                        input logic den, input logic dbit, input logic [3:0] bidx);
        b_scl = scl; b_sda = sda; b_stb = stb; b_den = den; b_dbit = dbit; b_bidx = bidx;
    endtask

    task automatic own_frame_start();
        setb(1, 1, 0, 0, 0, 0); b_gen = 1; b_ostart = 1; tick();
        b_ostart = 0; b_sda = 0; tick();
        b_scl = 0; tick();
        b_gen = 0;
    endtask

    task automatic bus_stop(input logic gen);
        b_gen = gen; b_stb = 0;
        b_scl = 0; b_sda = 0; tick();
        b_scl = 1; tick();
        b_sda = 1; tick();
        b_gen = 0;
    endtask

    task automatic addr_walk(input logic [6:0] a);
        own_frame_start();
        b_bcnt = 0;
        for (int i = 0; i < 7; i++) begin
            setb(0, a[6-i], 0, 1, 1, 4'(i)); tick();
            b_scl = 1; b_stb = 1; tick();
            b_stb = 0;
        end
        setb(0, 0, 0, 1, 1, 4'd7); tick();
        b_scl = 1; b_stb = 1; tick();
        b_stb = 0; b_scl = 0; tick();
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        #1;
        chk(arb_lost, 0, "R9 reset arb_lost");
        chk(retry_ok, 1, "R9 reset retry_ok");
        chk(tail_clk, 0, "R9 reset tail_clk");
        chk(slave_hit, 0, "R9 reset slave_hit");
        tick();

        // R10: mismatch outside an own frame is ignored
        setb(1, 0, 1, 1, 1, 4'd2); b_sda = 1; tick();
        b_scl = 0; tick();
        b_sda = 0; b_scl = 1; tick();
        #1 chk(arb_lost, 0, "R10 no loss outside own frame");
        b_stb = 0; b_scl = 0; tick();
        b_sda = 1; b_scl = 1; tick();

        own_frame_start();
        #1 chk(retry_ok, 0, "R4 busy after START");
        // R1: mismatch during SCL low is ignored
        setb(0, 0, 1, 1, 1, 4'd1); tick();
        #1 chk(arb_lost, 0, "R1 no compare while SCL low");
        setb(0, 0, 0, 1, 0, 4'd1);
        #1 chk(sda_oe, 1, "R2 drives low before loss");
        // R1: real loss
        setb(1, 0, 1, 1, 1, 4'd2); tick();
        b_stb = 0;
        #1 chk(arb_lost, 1, "R1 loss on high-phase mismatch");
        chk(tail_clk, 1, "R3 tail window opens");
        chk(retry_ok, 0, "R4 no retry while lost");
        b_dbit = 0;
        #1 chk(sda_oe, 0, "R2 released after loss");
        setb(0, 0, 0, 0, 0, 4'd5); tick();
        b_scl = 1; b_stb = 1; tick();
        b_stb = 0; b_scl = 0; tick();
        #1 chk(tail_clk, 1, "R3 tail holds mid byte");
        chk(arb_lost, 1, "R6 loss flag sticky");
        setb(1, 0, 1, 0, 0, 4'd8); tick();
        b_stb = 0;
        #1 chk(tail_clk, 0, "R3 tail closes after ack slot");
        b_clr = 1; tick();
        b_clr = 0;
        #1 chk(arb_lost, 0, "R6 cleared by clr_lost");
        #1 chk(retry_ok, 0, "R4 retry waits for STOP");
        bus_stop(0);
        #1 chk(retry_ok, 1, "R4 retry after STOP");

        // R5: acknowledge slot compared
        own_frame_start();
        setb(1, 0, 1, 1, 1, 4'd8); tick();
        b_stb = 0;
        #1 chk(arb_lost, 1, "R5 loss at ack slot");
        chk(tail_clk, 0, "R3 no tail for ack-slot loss");
        b_ostart = 1; b_gen = 1; b_scl = 0; tick();
        b_ostart = 0; b_gen = 0;
        #1 chk(arb_lost, 0, "R6 cleared by own_start");

        // R8: foreign STOP mid byte
        b_bidx = 4'd3;
        bus_stop(0);
        #1 chk(arb_lost, 1, "R8 foreign STOP is loss");
        chk(retry_ok, 1, "R4 STOP beats same-cycle loss");
        b_clr = 1; tick(); b_clr = 0;
        own_frame_start();
        b_bidx = 4'd3;
        bus_stop(1);
        #1 chk(arb_lost, 0, "R8 own STOP is not loss");
        b_ostop = 1; tick(); b_ostop = 0;

        // R7: address handoff
        b_addr = 7'h5A;
        addr_walk(7'h5A);
        #1 chk(slave_hit, 1, "R7 addressed as slave after loss");
        bus_stop(1);
        #1 chk(slave_hit, 0, "R7 cleared by STOP");
        b_clr = 1; tick(); b_clr = 0;
        addr_walk(7'h3B);
        #1 chk(slave_hit, 0, "R7 no hit on other address");
        bus_stop(1);
        b_clr = 1; b_ostop = 1; tick(); b_clr = 0; b_ostop = 0;

        // Random phase, checked each cycle against the model (R1-related tags inside tick)
        for (int n = 0; n < 4000; n++) begin
            b_scl    = ($urandom % 4) != 0;
            b_sda    = ($urandom % 3) != 0;
            b_stb    = $urandom % 2;
            b_den    = $urandom % 2;
            b_dbit   = $urandom % 2;
            b_bidx   = 4'($urandom_range(0, 8));
            b_bcnt   = 8'($urandom % 2);
            b_ostart = ($urandom % 20) == 0;
            b_ostop  = ($urandom % 30) == 0;
            b_gen    = ($urandom % 4) == 0;
            b_clr    = ($urandom % 25) == 0;
            tick();
        end
        setb(1, 1, 0, 0, 0, 0);
        b_ostart = 0; b_ostop = 0; b_gen = 0; b_clr = 0;
        tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule